// File: doc/BRIEF.md
# Partial Reconfiguration Data Sequencer

This block streams a partial-reconfiguration bitstream into a device configuration port, one 16-bit word at a time. A one-cycle start pulse begins a run. The block raises a request toward the port and waits for the port to report that it is ready. After a fixed lead-in it pulls words from an upstream valid/ready source and places them on the port's data bus.

When the bitstream is compressed or encrypted, the port needs each word for several clock cycles. A clock-to-data ratio parameter (1, 2 or 4) sets this hold time. The block watches the port's done and error lines. On either one it stops taking words and drops the request almost at once. It then keeps a clock-enable output high for a minimum number of cycles, so that the port clock keeps running while the port finishes.

At the end of a run, a sticky flag reports whether the run ended in error. The next start clears the flag. Illegal option sets are rejected when the design is elaborated.

Top module: `pr_word_feeder`

## Requirements
- R1: During and right after a synchronous active-high reset, the following outputs are all low: request, clock-enable, busy, error flag and source ready. The data bus reads 0.
- R2: A start pulse in the idle state raises request, clock-enable and busy from the next cycle. While the port has not yet reported ready, request stays high and source ready stays low.
- R3: The port's ready line is sampled at one clock edge. The first word is taken in the cycle that ends on the fourth edge after that one. The word shows on the data bus from that fourth edge on.
- R4: While streaming, source ready is high only in the last cycle of a word's hold window. With the source always valid, every word stays on the data bus for exactly CD_RATIO cycles. A ratio of 1 takes one word per cycle.
- R5: If the source is not valid when a hold window ends, the current word stays on the bus and source ready stays high. The next word is taken in the first cycle in which the source is valid, and it then gets a full window.
- R6: If done is seen during streaming, source ready is low in that same cycle. Request is low from the next cycle, which is within the 8-cycle limit. The data bus keeps its last word.
- R7: Clock-enable stays high for exactly TAIL_MIN cycles (80 by default) after the edge that samples done or error, and then goes low. Busy goes low one cycle after clock-enable.
- R8: An error seen during streaming stops the stream in the same cycle. Source ready is low in that cycle, no further word is taken, and request drops on the next cycle.
- R9: After a run that ended in error, the error flag is high once busy falls. It stays high while the block is idle and is cleared by the edge that accepts the next start. A run that ends with done leaves the flag low.
- R10: A done or error that arrives during the lead-in after ready is handled exactly as one that arrives during streaming: no word is taken, request drops on the next cycle, and the clock tail follows.
- R11: The option set is checked at elaboration. CD_RATIO must be 1, 2 or 4, and enhanced compression together with encryption is refused. A legal option set starts a run normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, shared with the configuration port |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Pulse that starts a reconfiguration run when idle |
| cfg_ready_i | input | 1 | Configuration port ready for data |
| cfg_done_i | input | 1 | Configuration port reports success |
| cfg_error_i | input | 1 | Configuration port reports a failure |
| src_data_i | input | DATA_W | Upstream bitstream word |
| src_valid_i | input | 1 | Upstream word valid |
| src_ready_o | output | 1 | Upstream word taken in this cycle when valid |
| cfg_req_o | output | 1 | Reconfiguration request to the port |
| cfg_data_o | output | DATA_W | Word presented to the configuration port |
| cfg_clk_en_o | output | 1 | Port clock must keep running |
| busy_o | output | 1 | A run is in progress |
| err_flag_o | output | 1 | Sticky: last run ended in error |

## Verification
Most wrong internal states show up at the ports within one clock. A hold or lead-in counter that is off by one moves the cycle in which source ready rises, and the word on the data bus then changes one cycle early or late. A state machine that misses done or error leaves request high on the following cycle, where both the bench and a property look for it. A tail counter error only appears when clock-enable falls, 80 cycles after the status pulse. Both the bench and a checker counter measure the length of that tail. A wrong sticky error flag is visible as soon as busy drops, and again after the next start.

// File: rtl/pr_feed_pkg.sv
package pr_feed_pkg;

    localparam int unsigned WORD_W = 16;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_REQ    = 3'd1,
        ST_WAIT   = 3'd2,
        ST_LEAD   = 3'd3,
        ST_STREAM = 3'd4,
        ST_TAIL   = 3'd5,
        ST_REL    = 3'd6
    } feed_state_e;

    // status lines coming back from the configuration port
    typedef struct packed {
        logic ready;
        logic done;
        logic error;
    } port_stat_t;

    // pacing strobes produced by the pacer
    typedef struct packed {
        logic take;
        logic load;
    } pace_t;

    function automatic bit ratio_legal(input int unsigned r);
        return (r == 1) || (r == 2) || (r == 4);
    endfunction

    function automatic bit in_xfer(input feed_state_e s);
        return (s == ST_LEAD) || (s == ST_STREAM);
    endfunction

    function automatic bit holds_req(input feed_state_e s);
        return (s == ST_REQ) || (s == ST_WAIT) || (s == ST_LEAD) || (s == ST_STREAM);
    endfunction

    function automatic bit holds_clk(input feed_state_e s);
        return holds_req(s) || (s == ST_TAIL);
    endfunction

endpackage

// File: rtl/pr_feed_pacer.sv
module pr_feed_pacer
    import pr_feed_pkg::*;
#(
    parameter int unsigned CD_RATIO    = 1,
    parameter int unsigned LEAD_CYCLES = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  feed_state_e state,
    input  logic        abort,
    input  logic        src_valid,
    output pace_t       pace
);
    localparam int unsigned LW = (LEAD_CYCLES > 1) ? $clog2(LEAD_CYCLES) : 1;
    localparam int unsigned HW = (CD_RATIO > 1) ? $clog2(CD_RATIO) : 1;

    logic [LW-1:0] lead_cnt;
    logic          lead_last;
    logic          hold_last;

    // lead-in counter: runs from zero on the first lead cycle, saturates
    always_ff @(posedge clk) begin
        if (rst) begin
            lead_cnt <= '0;
        end else if (state != ST_LEAD) begin
            lead_cnt <= '0;
        end else if (lead_cnt != LW'(LEAD_CYCLES - 1)) begin
            lead_cnt <= lead_cnt + 1'b1;
        end
    end

    assign lead_last = (state == ST_LEAD) && (lead_cnt == LW'(LEAD_CYCLES - 1));

    generate
        if (CD_RATIO == 1) begin : g_hold_single
            assign hold_last = 1'b1;
        end else begin : g_hold_multi
            logic [HW-1:0] hold_cnt;
            always_ff @(posedge clk) begin
                if (rst) begin
                    hold_cnt <= '0;
                end else if (pace.load) begin
                    hold_cnt <= '0;
                end else if (state != ST_STREAM) begin
                    hold_cnt <= '0;
                end else if (!hold_last) begin
                    hold_cnt <= hold_cnt + 1'b1;
                end
            end
            assign hold_last = (hold_cnt == HW'(CD_RATIO - 1));
        end
    endgenerate

    always_comb begin
        pace.take = !abort && (lead_last || ((state == ST_STREAM) && hold_last));
        pace.load = pace.take && src_valid;
    end

endmodule

// File: rtl/pr_feed_tail.sv
module pr_feed_tail #(
    parameter int unsigned TAIL_MIN = 80
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    output logic expired
);
    localparam int unsigned TW = (TAIL_MIN > 1) ? $clog2(TAIL_MIN) : 1;

    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            cnt <= '0;
        end else if (!expired) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = active && (cnt == TW'(TAIL_MIN - 1));

endmodule

// File: rtl/pr_feed_fsm.sv
module pr_feed_fsm
    import pr_feed_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  port_stat_t  stat,
    input  logic        load,
    input  logic        tail_done,
    output feed_state_e state,
    output logic        err_flag
);
    feed_state_e nxt;
    logic        err_seen;
    logic        accept;

    assign accept = (state == ST_IDLE) && start;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (start) nxt = ST_REQ;
            ST_REQ:    nxt = ST_WAIT;
            ST_WAIT:   if (stat.ready) nxt = ST_LEAD;
            ST_LEAD: begin
                if (stat.error || stat.done) nxt = ST_TAIL;
                else if (load)               nxt = ST_STREAM;
            end
            ST_STREAM: if (stat.error || stat.done) nxt = ST_TAIL;
            ST_TAIL:   if (tail_done) nxt = ST_REL;
            ST_REL:    nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_seen <= 1'b0;
            err_flag <= 1'b0;
        end else begin
            if (accept) begin
                err_seen <= 1'b0;
            end else if (in_xfer(state) && stat.error) begin
                err_seen <= 1'b1;
            end
            if (accept) begin
                err_flag <= 1'b0;
            end else if (state == ST_REL) begin
                err_flag <= err_seen;
            end
        end
    end

endmodule

// File: rtl/pr_word_feeder.sv
module pr_word_feeder
    import pr_feed_pkg::*;
#(
    parameter int unsigned DATA_W       = WORD_W,
    parameter int unsigned CD_RATIO     = 1,
    parameter int unsigned LEAD_CYCLES  = 4,
    parameter int unsigned TAIL_MIN     = 80,
    parameter int unsigned REQ_DROP_MAX = 8,
    parameter bit          ENH_COMP     = 1'b0,
    parameter bit          ENCRYPT      = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              cfg_ready_i,
    input  logic              cfg_done_i,
    input  logic              cfg_error_i,
    input  logic [DATA_W-1:0] src_data_i,
    input  logic              src_valid_i,
    output logic              src_ready_o,
    output logic              cfg_req_o,
    output logic [DATA_W-1:0] cfg_data_o,
    output logic              cfg_clk_en_o,
    output logic              busy_o,
    output logic              err_flag_o
);
    // R11: option sets refused at elaboration
    generate
        if (!ratio_legal(CD_RATIO)) begin : g_bad_ratio
            $error("pr_word_feeder: CD_RATIO must be 1, 2 or 4");
        end
        if (ENH_COMP && ENCRYPT) begin : g_bad_combo
            $error("pr_word_feeder: enhanced compression cannot be combined with encryption");
        end
        if (LEAD_CYCLES < 1 || TAIL_MIN < 2 || REQ_DROP_MAX < 1) begin : g_bad_timing
            $error("pr_word_feeder: timing parameters out of range");
        end
    endgenerate

    feed_state_e state;
    port_stat_t  stat;
    pace_t       pace;
    logic        tail_done;
    logic        err_flag;

    assign stat.ready = cfg_ready_i;
    assign stat.done  = cfg_done_i;
    assign stat.error = cfg_error_i;

    pr_feed_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start     (start_i),
        .stat      (stat),
        .load      (pace.load),
        .tail_done (tail_done),
        .state     (state),
        .err_flag  (err_flag)
    );

    pr_feed_pacer #(
        .CD_RATIO    (CD_RATIO),
        .LEAD_CYCLES (LEAD_CYCLES)
    ) u_pacer (
        .clk       (clk),
        .rst       (rst),
        .state     (state),
        .abort     (cfg_done_i || cfg_error_i),
        .src_valid (src_valid_i),
        .pace      (pace)
    );

    pr_feed_tail #(
        .TAIL_MIN (TAIL_MIN)
    ) u_tail (
        .clk     (clk),
        .rst     (rst),
        .active  (state == ST_TAIL),
        .expired (tail_done)
    );

    logic [DATA_W-1:0] word_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else if (pace.load) begin
            word_q <= src_data_i;
        end
    end

    assign src_ready_o  = pace.take;
    assign cfg_data_o   = word_q;
    assign cfg_req_o    = holds_req(state);
    assign cfg_clk_en_o = holds_clk(state);
    assign busy_o       = (state != ST_IDLE);
    assign err_flag_o   = err_flag;

endmodule

// File: rtl/pr_word_feeder_chk.sv
module pr_word_feeder_chk
    import pr_feed_pkg::*;
#(
    parameter int unsigned DATA_W      = WORD_W,
    parameter int unsigned CD_RATIO    = 1,
    parameter int unsigned LEAD_CYCLES = 4,
    parameter int unsigned TAIL_MIN    = 80
) (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic              cfg_done_i,
    input logic              cfg_error_i,
    input logic              src_valid_i,
    input logic              src_ready_o,
    input logic              cfg_req_o,
    input logic [DATA_W-1:0] cfg_data_o,
    input logic              cfg_clk_en_o,
    input logic              busy_o,
    input logic              err_flag_o,
    input feed_state_e       st
);
    int unsigned tail_len;
    int unsigned lead_len;
    logic [7:0]  since_load;

    always_ff @(posedge clk) begin
        if (rst || st != ST_TAIL) tail_len <= 0;
        else                      tail_len <= tail_len + 1;
        if (rst || st != ST_LEAD) lead_len <= 0;
        else                      lead_len <= lead_len + 1;
        if (rst || (src_ready_o && src_valid_i)) since_load <= 8'd1;
        else if (since_load != 8'hFF)            since_load <= since_load + 8'd1;
    end

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (!cfg_req_o && !busy_o && !cfg_clk_en_o && !err_flag_o));

    p_req_on_start_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && start_i) |=> (cfg_req_o && cfg_clk_en_o));

    p_lead_exact_r3: assert property (@(posedge clk) disable iff (rst)
        (st == ST_LEAD && src_ready_o) |-> (lead_len == LEAD_CYCLES - 1));

    p_hold_window_r4: assert property (@(posedge clk) disable iff (rst)
        (st == ST_STREAM && src_ready_o && src_valid_i) |-> (since_load >= CD_RATIO));

    p_word_stable_r5: assert property (@(posedge clk) disable iff (rst)
        !(src_ready_o && src_valid_i) |=> $stable(cfg_data_o));

    p_req_drop_r6: assert property (@(posedge clk) disable iff (rst)
        (in_xfer(st) && cfg_done_i) |=> !cfg_req_o);

    p_tail_min_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(cfg_clk_en_o) |-> (tail_len >= TAIL_MIN));

    p_err_stop_r8: assert property (@(posedge clk) disable iff (rst)
        (in_xfer(st) && cfg_error_i) |-> !src_ready_o);

    p_err_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && start_i) |=> !err_flag_o);

    p_take_needs_req_r10: assert property (@(posedge clk) disable iff (rst)
        src_ready_o |-> cfg_req_o);

endmodule

bind pr_word_feeder pr_word_feeder_chk #(
    .DATA_W      (DATA_W),
    .CD_RATIO    (CD_RATIO),
    .LEAD_CYCLES (LEAD_CYCLES),
    .TAIL_MIN    (TAIL_MIN)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .cfg_done_i   (cfg_done_i),
    .cfg_error_i  (cfg_error_i),
    .src_valid_i  (src_valid_i),
    .src_ready_o  (src_ready_o),
    .cfg_req_o    (cfg_req_o),
    .cfg_data_o   (cfg_data_o),
    .cfg_clk_en_o (cfg_clk_en_o),
    .busy_o       (busy_o),
    .err_flag_o   (err_flag_o),
    .st           (state)
);

// File: tb/pr_word_feeder_tb_top.sv
module pr_word_feeder_tb_top;
    localparam int unsigned CD   = 4;
    localparam int unsigned LEAD = 4;
    localparam int unsigned TAIL = 80;
    localparam int unsigned NV   = 10;
    localparam int unsigned WD   = 20000;

    typedef struct packed {
        logic [3:0]  gap;
        logic [15:0] word;
    } vec_t;

    // gap = idle cycles of the source before it offers the word
    localparam vec_t VEC [NV] = '{
        '{4'd0, 16'h3C5A}, '{4'd0, 16'hA1B2}, '{4'd2, 16'h0FF0}, '{4'd6, 16'h1234},
        '{4'd0, 16'hFFFF}, '{4'd9, 16'h0001}, '{4'd0, 16'h8000}, '{4'd3, 16'hC3C3},
        '{4'd0, 16'h5A5A}, '{4'd0, 16'h7E81}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        cfg_ready_i = 1'b0;
    logic        cfg_done_i = 1'b0;
    logic        cfg_error_i = 1'b0;
    logic [15:0] src_data_i = '0;
    logic        src_valid_i = 1'b0;
    logic        src_ready_o;
    logic        cfg_req_o;
    logic [15:0] cfg_data_o;
    logic        cfg_clk_en_o;
    logic        busy_o;
    logic        err_flag_o;

    always #2 clk = ~clk;

    pr_word_feeder #(
        .DATA_W   (16),
        .CD_RATIO (CD),
        .LEAD_CYCLES (LEAD),
        .TAIL_MIN (TAIL),
        .ENH_COMP (1'b1),
        .ENCRYPT  (1'b0)
    ) dut_i (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .cfg_ready_i  (cfg_ready_i),
        .cfg_done_i   (cfg_done_i),
        .cfg_error_i  (cfg_error_i),
        .src_data_i   (src_data_i),
        .src_valid_i  (src_valid_i),
        .src_ready_o  (src_ready_o),
        .cfg_req_o    (cfg_req_o),
        .cfg_data_o   (cfg_data_o),
        .cfg_clk_en_o (cfg_clk_en_o),
        .busy_o       (busy_o),
        .err_flag_o   (err_flag_o)
    );

    int n_chk = 0;
    int n_fail = 0;

    // bench model of the stream
    int          wait_left;
    int          idx;
    int          gap_left;
    int          since_rdy;
    int          first_at;
    logic [15:0] exp_data = '0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // one streaming cycle; entered at edge+1
    task automatic stream_cycle();
        bit fire;
        chk(cfg_data_o == exp_data, "R5 word on bus", cfg_data_o, exp_data);
        if (gap_left > 0) begin
            src_valid_i = 1'b0;
            gap_left--;
        end else begin
            src_valid_i = (idx < NV);
            if (idx < NV) src_data_i = VEC[idx].word;
        end
        #1;
        chk(src_ready_o == (wait_left == 0), "R4 source ready timing", src_ready_o, (wait_left == 0));
        fire = src_valid_i && (wait_left == 0);
        step();
        since_rdy++;
        if (fire) begin
            exp_data  = VEC[idx].word;
            if (idx == 0) first_at = since_rdy;
            idx++;
            wait_left = CD - 1;
            gap_left  = (idx < NV) ? int'(VEC[idx].gap) : 0;
        end else if (wait_left > 0) begin
            wait_left--;
        end
    endtask

    task automatic begin_run();
        start_i = 1'b1;
        step();
        start_i = 1'b0;
        chk(cfg_req_o == 1'b1, "R2 request after start", cfg_req_o, 1);
        chk(cfg_clk_en_o == 1'b1, "R2 clock enable after start", cfg_clk_en_o, 1);
        chk(err_flag_o == 1'b0, "R9 flag cleared by start", err_flag_o, 0);
        for (int i = 0; i < 3; i++) begin
            step();
            chk(cfg_req_o == 1'b1, "R2 request held before ready", cfg_req_o, 1);
            chk(src_ready_o == 1'b0, "R2 no take before ready", src_ready_o, 0);
        end
        cfg_ready_i = 1'b1;
        step();
        cfg_ready_i = 1'b0;
        wait_left = LEAD - 1;
        idx       = 0;
        gap_left  = int'(VEC[0].gap);
        since_rdy = 0;
        first_at  = -1;
    endtask

    task automatic tail_check(input string tag);
        int hi = 0;
        while (cfg_clk_en_o && hi < 1000) begin
            hi++;
            step();
        end
        chk(hi == TAIL, tag, hi, TAIL);
        chk(busy_o == 1'b1, "R7 busy one cycle past tail", busy_o, 1);
        step();
        chk(busy_o == 1'b0, "R7 idle after release", busy_o, 0);
    endtask

    initial begin : watchdog
        repeat (WD) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R7: cycles=%0d expected<%0d", WD, WD);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        // R1: reset state
        repeat (3) step();
        chk(cfg_req_o == 1'b0, "R1 request in reset", cfg_req_o, 0);
        chk(busy_o == 1'b0, "R1 busy in reset", busy_o, 0);
        chk(cfg_clk_en_o == 1'b0, "R1 clock enable in reset", cfg_clk_en_o, 0);
        chk(err_flag_o == 1'b0, "R1 flag in reset", err_flag_o, 0);
        chk(src_ready_o == 1'b0, "R1 source ready in reset", src_ready_o, 0);
        chk(cfg_data_o == 16'h0, "R1 data in reset", cfg_data_o, 0);
        rst = 1'b0;
        step();

        // run A: full table, ended by done
        begin_run();
        chk(busy_o == 1'b1, "R11 legal option set runs", busy_o, 1);
        for (int g = 0; g < 500 && !(idx == NV && wait_left == 0); g++) stream_cycle();
        chk(first_at == LEAD, "R3 first word placement", first_at, LEAD);
        chk(idx == NV, "R4 all words consumed", idx, NV);
        chk(cfg_data_o == VEC[NV-1].word, "R4 last word on bus", cfg_data_o, VEC[NV-1].word);
        cfg_done_i  = 1'b1;
        src_valid_i = 1'b1;
        src_data_i  = 16'hDEAD;
        #1;
        chk(src_ready_o == 1'b0, "R6 no take on done", src_ready_o, 0);
        step();
        cfg_done_i  = 1'b0;
        src_valid_i = 1'b0;
        chk(cfg_req_o == 1'b0, "R6 request dropped", cfg_req_o, 0);
        chk(cfg_data_o == VEC[NV-1].word, "R6 data kept", cfg_data_o, VEC[NV-1].word);
        tail_check("R7 tail after done");
        chk(err_flag_o == 1'b0, "R9 done leaves flag low", err_flag_o, 0);

        // run B: error in the middle of the stream
        repeat (2) step();
        begin_run();
        for (int g = 0; g < 500 && !(idx == 3 && wait_left == 0); g++) stream_cycle();
        exp_data    = cfg_data_o;
        cfg_error_i = 1'b1;
        src_valid_i = 1'b1;
        src_data_i  = VEC[3].word;
        #1;
        chk(src_ready_o == 1'b0, "R8 no take on error", src_ready_o, 0);
        step();
        cfg_error_i = 1'b0;
        src_valid_i = 1'b0;
        chk(cfg_req_o == 1'b0, "R8 request dropped on error", cfg_req_o, 0);
        chk(cfg_data_o == exp_data, "R8 data frozen", cfg_data_o, exp_data);
        tail_check("R7 tail after error");
        chk(err_flag_o == 1'b1, "R9 flag after error run", err_flag_o, 1);
        repeat (5) step();
        chk(err_flag_o == 1'b1, "R9 flag sticky while idle", err_flag_o, 1);

        // run C: done during lead-in
        begin_run();
        exp_data = cfg_data_o;
        step();
        step();
        cfg_done_i  = 1'b1;
        src_valid_i = 1'b1;
        src_data_i  = 16'hBEEF;
        #1;
        chk(src_ready_o == 1'b0, "R10 no take on done in lead-in", src_ready_o, 0);
        step();
        cfg_done_i  = 1'b0;
        src_valid_i = 1'b0;
        chk(cfg_req_o == 1'b0, "R10 request dropped in lead-in", cfg_req_o, 0);
        chk(cfg_data_o == exp_data, "R10 data untouched", cfg_data_o, exp_data);
        tail_check("R10 tail after lead-in done");
        chk(err_flag_o == 1'b0, "R9 flag low after done run", err_flag_o, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule